// File: doc/BRIEF.md
# Interleaved Thread Fetch Scheduler

This block sits at the front of a three-stage fetch, decode and execute pipeline. Each stage takes one clock, so up to three instructions are in flight. On every clock it picks one hardware thread and hands that thread's next instruction word to decode, or it sends a bubble. It never lets a thread issue on two clocks in a row. A result therefore always leaves execute before the same thread's next instruction needs it, and the pipeline needs no forwarding paths.

Each thread owns a small FIFO of short-format instruction words, loaded through a per-thread push strobe. A microcode ROM is shared by all threads and holds long-format words. Each thread has its own routine in that ROM. An event such as an interrupt, raised for a thread that is allowed to take events, does not stall anything. The next issue slot of that thread comes from the first word of its ROM routine instead of its queue. The routine then steps through the ROM on that thread's following slots until it issues a return word. Queue fetch then resumes. Events can be limited to one chosen thread, so the other threads keep a fixed issue rate.

Top module: `tfs_sched`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `iss_valid` is low. Reset empties every queue, drops every pending event and clears every thread's in-ROM state.
- R2: No thread ID appears on `iss_tid` in two consecutive cycles that both have `iss_valid` high.
- R3: When exactly one thread has work and its queue never runs dry, it issues on every second clock.
- R4: A thread is eligible if it is in a ROM routine, has a pending event, or has a non-empty queue, and it did not issue on the previous clock. The grant goes round-robin among eligible threads, and the search starts at the thread after the last one granted. After reset the search starts at thread 0.
- R5: Queue words of a thread issue in push order, with `iss_rom` low, one cycle after the decision that selects them. A word pushed on one clock edge can issue from the next edge onward.
- R6: A push to a queue that already holds QDEPTH words before that edge is dropped, even when the same edge pops the queue.
- R7: An event on an enabled thread is captured at a clock edge. Its first word comes from ROM address tid*RLEN, in the thread's first issue slot after capture, with `iss_rom` high. Later slots issue consecutive ROM addresses. The ROM word at address a is {opcode, a[5:0], (a*0x1357+0x2A) mod 2^22}, with opcode 0xF on the last word of each RLEN-word routine and 0xA on the others.
- R8: After a thread issues an opcode-0xF word, its next slot goes back to its queue, with the queue head unchanged. If an event arrived during the routine, that next slot re-enters the routine at its first address instead.
- R9: An event on a thread whose bit in EVT_EN is clear has no effect. That thread issues only queue words, and a thread with an empty queue issues nothing.
- R10: When no thread is eligible, `iss_valid` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_en | input | NT | Per-thread push strobe into the thread's queue |
| push_data | input | NT*32 | Per-thread push words, thread t in bits [32t+31:32t] |
| evt_req | input | NT | Per-thread event request, captured on each edge |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_tid | output | clog2(NT) | Thread that owns the issued word |
| iss_word | output | 32 | Issued instruction word |
| iss_rom | output | 1 | Word came from the microcode ROM |

## Verification
Per-thread state that goes wrong shows up at the ports within one or two issue slots of the thread involved. A stale eligibility bit lets the same ID appear twice in a row. A lost in-ROM flag sends a queue word where a ROM address one above the last was expected. A bad queue pointer repeats or skips a word against the pushed order. A broken round-robin pointer changes the order of IDs in the first cycles after all threads are loaded. The sweeps cover one active thread, all threads active, a sparse subset, queue overflow, event entry, event re-entry, a ROM routine interleaved with queue work, and a disabled event. Every issue is logged with its cycle number, so both gaps and contents can be checked.

// File: rtl/tfs_pkg.sv
package tfs_pkg;

    localparam int INSN_W = 32;
    localparam int OPC_W  = 4;
    localparam int TAG_W  = 6;
    localparam int LIMM_W = 22;

    localparam logic [OPC_W-1:0] OPC_UBODY = 4'hA;
    localparam logic [OPC_W-1:0] OPC_URET  = 4'hF;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_QUEUE,
        SRC_ROM_ENTER,
        SRC_ROM_STEP
    } fetch_src_e;

    typedef struct packed {
        logic              vld;
        logic              from_rom;
        logic [INSN_W-1:0] word;
    } issue_t;

    // Long-format microcode word at a ROM address; the last word of each
    // routine carries the return opcode.
    function automatic logic [INSN_W-1:0] ucode_word(input int unsigned addr,
                                                     input int unsigned rlen);
        logic [OPC_W-1:0]  op;
        logic [LIMM_W-1:0] imm;
        op  = ((addr % rlen) == rlen - 1) ? OPC_URET : OPC_UBODY;
        imm = LIMM_W'(addr * 32'h1357 + 32'h2A);
        return {op, TAG_W'(addr), imm};
    endfunction

    function automatic logic word_is_ret(input logic [INSN_W-1:0] w);
        return w[INSN_W-1 -: OPC_W] == OPC_URET;
    endfunction

endpackage

// File: rtl/tfs_thread_queue.sv
module tfs_thread_queue #(
    parameter int DEPTH = 4,
    parameter int W     = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         nonempty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;
    logic          accept, take;

    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign accept   = push && (cnt_q < CW'(DEPTH));
    assign take     = pop && (cnt_q != '0);
    assign nonempty = (cnt_q != '0);
    assign head     = mem[rd_q];

    always_ff @(posedge clk) begin
        if (accept) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (accept) wr_q <= ptr_inc(wr_q);
            if (take)   rd_q <= ptr_inc(rd_q);
            case ({accept, take})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/tfs_rr_pick.sv
module tfs_rr_pick #(
    parameter int N  = 4,
    parameter int TW = 2
) (
    input  logic [N-1:0]  req,
    input  logic [TW-1:0] last,
    output logic          gnt_any,
    output logic [TW-1:0] gnt_id
);
    always_comb begin
        gnt_any = 1'b0;
        gnt_id  = '0;
        for (int k = 1; k <= N; k++) begin
            if (!gnt_any && req[(int'(last) + k) % N]) begin
                gnt_any = 1'b1;
                gnt_id  = TW'((int'(last) + k) % N);
            end
        end
    end
endmodule

// File: rtl/tfs_ucode_rom.sv
module tfs_ucode_rom
    import tfs_pkg::*;
#(
    parameter int RLEN = 3,
    parameter int AW   = 4
) (
    input  logic [AW-1:0]     addr,
    output logic [INSN_W-1:0] word
);
    assign word = ucode_word(32'(addr), RLEN);
endmodule

// File: rtl/tfs_sched.sv
module tfs_sched
    import tfs_pkg::*;
#(
    parameter int            NT     = 4,
    parameter int            QDEPTH = 4,
    parameter int            RLEN   = 3,
    parameter logic [NT-1:0] EVT_EN = {{(NT-1){1'b0}}, 1'b1},
    localparam int           TW     = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NT-1:0]        push_en,
    input  logic [NT*INSN_W-1:0] push_data,
    input  logic [NT-1:0]        evt_req,
    output logic                 iss_valid,
    output logic [TW-1:0]        iss_tid,
    output logic [INSN_W-1:0]    iss_word,
    output logic                 iss_rom
);
    localparam int ROM_N = NT * RLEN;
    localparam int RA_W  = (ROM_N > 1) ? $clog2(ROM_N) : 1;

    logic [NT-1:0]     q_ne, q_pop, elig;
    logic [INSN_W-1:0] q_head [NT];
    logic [NT-1:0]     in_rom_q, evt_pend_q;
    logic [RA_W-1:0]   rom_pc_q [NT];
    logic [TW-1:0]     rr_last_q;

    logic              gnt_any;
    logic [TW-1:0]     gnt_id;
    fetch_src_e        src;
    logic [RA_W-1:0]   rom_addr;
    logic [INSN_W-1:0] rom_word;
    issue_t            nxt;

    // Per-thread instruction queues
    for (genvar t = 0; t < NT; t++) begin : g_q
        tfs_thread_queue #(.DEPTH(QDEPTH), .W(INSN_W)) u_q (
            .clk      (clk),
            .rst      (rst),
            .push     (push_en[t]),
            .din      (push_data[t*INSN_W +: INSN_W]),
            .pop      (q_pop[t]),
            .head     (q_head[t]),
            .nonempty (q_ne[t])
        );
        assign elig[t] = (in_rom_q[t] | evt_pend_q[t] | q_ne[t])
                       & ~(iss_valid && (iss_tid == TW'(t)));
        assign q_pop[t] = (src == SRC_QUEUE) && (gnt_id == TW'(t));
    end

    tfs_rr_pick #(.N(NT), .TW(TW)) u_pick (
        .req     (elig),
        .last    (rr_last_q),
        .gnt_any (gnt_any),
        .gnt_id  (gnt_id)
    );

    // Fetch source for the granted thread
    always_comb begin
        if (!gnt_any)                src = SRC_NONE;
        else if (in_rom_q[gnt_id])   src = SRC_ROM_STEP;
        else if (evt_pend_q[gnt_id]) src = SRC_ROM_ENTER;
        else                         src = SRC_QUEUE;
    end

    assign rom_addr = (src == SRC_ROM_STEP) ? rom_pc_q[gnt_id]
                                            : RA_W'(int'(gnt_id) * RLEN);

    tfs_ucode_rom #(.RLEN(RLEN), .AW(RA_W)) u_rom (
        .addr (rom_addr),
        .word (rom_word)
    );

    always_comb begin
        nxt.vld      = gnt_any;
        nxt.from_rom = (src == SRC_ROM_STEP) || (src == SRC_ROM_ENTER);
        nxt.word     = (src == SRC_QUEUE) ? q_head[gnt_id] : rom_word;
    end

    // Per-thread microcode state
    always_ff @(posedge clk) begin
        if (rst) begin
            in_rom_q   <= '0;
            evt_pend_q <= '0;
            for (int t = 0; t < NT; t++) rom_pc_q[t] <= '0;
        end else begin
            for (int t = 0; t < NT; t++) begin
                if (gnt_any && (gnt_id == TW'(t)) && (src == SRC_ROM_ENTER)) begin
                    evt_pend_q[t] <= evt_req[t] & EVT_EN[t];
                    in_rom_q[t]   <= 1'b1;
                    rom_pc_q[t]   <= RA_W'(t * RLEN + 1);
                end else begin
                    evt_pend_q[t] <= evt_pend_q[t] | (evt_req[t] & EVT_EN[t]);
                    if (gnt_any && (gnt_id == TW'(t)) && (src == SRC_ROM_STEP)) begin
                        if (word_is_ret(rom_word)) in_rom_q[t] <= 1'b0;
                        else                       rom_pc_q[t] <= rom_pc_q[t] + RA_W'(1);
                    end
                end
            end
        end
    end

    // Fetch output register
    always_ff @(posedge clk) begin
        if (rst) begin
            iss_valid <= 1'b0;
            iss_tid   <= '0;
            iss_word  <= '0;
            iss_rom   <= 1'b0;
            rr_last_q <= TW'(NT - 1);
        end else begin
            iss_valid <= nxt.vld;
            iss_tid   <= gnt_id;
            iss_word  <= nxt.word;
            iss_rom   <= nxt.vld && nxt.from_rom;
            if (gnt_any) rr_last_q <= gnt_id;
        end
    end
endmodule

// File: rtl/tfs_sched_chk.sv
module tfs_sched_chk
    import tfs_pkg::*;
#(
    parameter int NT   = 4,
    parameter int TW   = 2,
    parameter int RLEN = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              iss_valid,
    input logic [TW-1:0]     iss_tid,
    input logic [INSN_W-1:0] iss_word,
    input logic              iss_rom,
    input logic              gnt_any
);
    logic             walk_q [NT];
    logic             ret_q  [NT];
    logic [TAG_W-1:0] tag_q  [NT];
    logic [TAG_W-1:0] cur_tag;
    logic [OPC_W-1:0] cur_op;

    assign cur_tag = iss_word[LIMM_W +: TAG_W];
    assign cur_op  = iss_word[INSN_W-1 -: OPC_W];

    p_reset_quiet_r1: assert property (@(posedge clk) rst |=> !iss_valid)
        else $error("reset did not silence issue");

    p_no_repeat_r2: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && $past(iss_valid)) |-> (iss_tid != $past(iss_tid)))
        else $error("thread issued on adjacent clocks");

    p_rom_opcode_r7: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_rom) |-> (cur_op == OPC_UBODY || cur_op == OPC_URET))
        else $error("ROM word with unknown opcode");

    p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
        !gnt_any |=> !iss_valid)
        else $error("issue without an eligible thread");

    // Track, per thread, what its previous issue was
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int t = 0; t < NT; t++) begin
                walk_q[t] <= 1'b0;
                ret_q[t]  <= 1'b0;
                tag_q[t]  <= '0;
            end
        end else if (iss_valid) begin
            walk_q[iss_tid] <= iss_rom && (cur_op == OPC_UBODY);
            ret_q[iss_tid]  <= iss_rom && (cur_op == OPC_URET);
            tag_q[iss_tid]  <= cur_tag;
        end
    end

    always @(negedge clk) begin
        if (!rst && iss_valid && walk_q[iss_tid]) begin
            p_rom_walk_r7: assert (iss_rom && cur_tag == tag_q[iss_tid] + TAG_W'(1))
                else $error("ROM routine did not step by one");
        end
        if (!rst && iss_valid && ret_q[iss_tid] && iss_rom) begin
            p_resume_after_ret_r8: assert (cur_tag == TAG_W'(int'(iss_tid) * RLEN))
                else $error("after return, ROM fetch not at routine start");
        end
    end
endmodule

bind tfs_sched tfs_sched_chk #(.NT(NT), .TW(TW), .RLEN(RLEN)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .iss_valid (iss_valid),
    .iss_tid   (iss_tid),
    .iss_word  (iss_word),
    .iss_rom   (iss_rom),
    .gnt_any   (gnt_any)
);

// File: tb/tfs_sched_bench.sv
`timescale 1ns/1ps
module tfs_sched_bench;
    localparam int NT = 4;
    localparam int QD = 4;
    localparam int RL = 3;
    localparam int TW = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NT-1:0]    push_en = '0;
    logic [31:0]      pw [NT];
    logic [NT*32-1:0] push_data;
    logic [NT-1:0]    evt_req = '0;
    logic             iss_valid;
    logic [TW-1:0]    iss_tid;
    logic [31:0]      iss_word;
    logic             iss_rom;

    assign push_data = {pw[3], pw[2], pw[1], pw[0]};

    tfs_sched #(.NT(NT), .QDEPTH(QD), .RLEN(RL), .EVT_EN(4'b0001)) u_tfs_sched (
        .clk(clk), .rst(rst), .push_en(push_en), .push_data(push_data),
        .evt_req(evt_req), .iss_valid(iss_valid), .iss_tid(iss_tid),
        .iss_word(iss_word), .iss_rom(iss_rom)
    );

    always #2.5 clk = ~clk;

    int tests = 0;
    int fails = 0;

    // Issue log, sampled mid-cycle
    int          cyc = 0;
    logic        rec = 1'b0;
    int          lg_n = 0;
    int          lg_cyc  [64];
    logic [1:0]  lg_tid  [64];
    logic [31:0] lg_word [64];
    logic        lg_rom  [64];

    always @(negedge clk) begin
        cyc++;
        if (rec && iss_valid && lg_n < 64) begin
            lg_cyc[lg_n]  = cyc;
            lg_tid[lg_n]  = iss_tid;
            lg_word[lg_n] = iss_word;
            lg_rom[lg_n]  = iss_rom;
            lg_n++;
        end
    end

    initial begin
        #(200000 * 5);
        tests++;
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    function automatic logic [31:0] rom_exp(input int a);
        logic [3:0]  op;
        logic [21:0] imm;
        op  = ((a % RL) == RL - 1) ? 4'hF : 4'hA;
        imm = 22'(a * 32'h1357 + 32'h2A);
        return {op, 6'(a), imm};
    endfunction

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        push_en = '0;
        evt_req = '0;
        repeat (n) step();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        rec = 1'b0;
        push_en = '0;
        evt_req = '0;
        repeat (3) step();
        rst = 1'b0;
        lg_n = 0;
        rec = 1'b1;
    endtask

    task automatic exp_issue(input string req, input int i, input int tid,
                             input logic [31:0] word, input logic rom);
        chk(req, $sformatf("issue %0d tid", i), longint'(lg_tid[i]), longint'(tid));
        chk(req, $sformatf("issue %0d word", i), longint'(lg_word[i]), longint'(word));
        chk(req, $sformatf("issue %0d rom", i), longint'(lg_rom[i]), longint'(rom));
    endtask

    task automatic exp_gaps(input string req, input int n, input int gap);
        for (int i = 1; i < n; i++)
            chk(req, $sformatf("gap before issue %0d", i),
                longint'(lg_cyc[i] - lg_cyc[i-1]), longint'(gap));
    endtask

    initial begin
        for (int t = 0; t < NT; t++) pw[t] = '0;

        // R1 / R10: reset state and idle with empty queues
        rst = 1'b1;
        repeat (3) begin
            step();
            chk("R1", "valid during reset", longint'(iss_valid), 0);
        end
        rst = 1'b0;
        lg_n = 0;
        rec = 1'b1;
        idle(8);
        chk("R10", "issues with empty queues", lg_n, 0);

        // R3 / R5: one active thread, queue kept busy
        do_reset();
        for (int i = 0; i < 4; i++) begin
            pw[2] = 32'h2000_0000 + i;
            push_en = 4'b0100;
            step();
        end
        idle(14);
        chk("R3", "single thread issue count", lg_n, 4);
        for (int i = 0; i < 4; i++) exp_issue("R5", i, 2, 32'h2000_0000 + i, 1'b0);
        exp_gaps("R3", 4, 2);

        // R6: overflow while draining at half rate
        do_reset();
        for (int i = 0; i < 8; i++) begin
            pw[1] = 32'h1100_0000 + i;
            push_en = 4'b0010;
            step();
        end
        idle(20);
        chk("R6", "issued after overflow", lg_n, 7);
        for (int i = 0; i < 7; i++) exp_issue("R6", i, 1, 32'h1100_0000 + i, 1'b0);
        exp_gaps("R3", 7, 2);

        // R4: all threads loaded
        do_reset();
        for (int k = 0; k < 2; k++) begin
            for (int t = 0; t < NT; t++) pw[t] = {8'(t), 8'h5A, 16'(k)};
            push_en = 4'b1111;
            step();
        end
        idle(12);
        chk("R4", "all-thread issue count", lg_n, 8);
        for (int i = 0; i < 8; i++)
            exp_issue("R4", i, i % NT, {8'(i % NT), 8'h5A, 16'(i / NT)}, 1'b0);
        exp_gaps("R4", 8, 1);

        // R4: sparse subset
        do_reset();
        for (int k = 0; k < 2; k++) begin
            pw[1] = 32'hB100 + k;
            pw[3] = 32'hB300 + k;
            push_en = 4'b1010;
            step();
        end
        idle(10);
        chk("R4", "sparse issue count", lg_n, 4);
        exp_issue("R4", 0, 1, 32'hB100, 1'b0);
        exp_issue("R4", 1, 3, 32'hB300, 1'b0);
        exp_issue("R4", 2, 1, 32'hB101, 1'b0);
        exp_issue("R4", 3, 3, 32'hB301, 1'b0);
        exp_gaps("R4", 4, 1);

        // R7 / R8: event between two queue words on thread 0
        do_reset();
        pw[0] = 32'hC0DE_0000;
        push_en = 4'b0001;
        step();
        pw[0] = 32'hC0DE_0001;
        evt_req = 4'b0001;
        step();
        idle(20);
        chk("R7", "event run issue count", lg_n, 5);
        exp_issue("R5", 0, 0, 32'hC0DE_0000, 1'b0);
        for (int a = 0; a < RL; a++) exp_issue("R7", 1 + a, 0, rom_exp(a), 1'b1);
        exp_issue("R8", 4, 0, 32'hC0DE_0001, 1'b0);
        exp_gaps("R7", 5, 2);

        // R8: second event during the routine re-enters after return
        do_reset();
        evt_req = 4'b0001;
        step();
        evt_req = 4'b0000;
        step();
        evt_req = 4'b0001;
        step();
        idle(20);
        chk("R8", "re-entry issue count", lg_n, 6);
        for (int i = 0; i < 6; i++) exp_issue("R8", i, 0, rom_exp(i % RL), 1'b1);
        exp_gaps("R8", 6, 2);

        // R7 / R4: ROM routine interleaved with another thread's queue
        do_reset();
        for (int i = 0; i < 3; i++) begin
            pw[1] = 32'hD100 + i;
            push_en = 4'b0010;
            evt_req = (i == 0) ? 4'b0001 : 4'b0000;
            step();
        end
        idle(12);
        chk("R7", "interleave issue count", lg_n, 6);
        for (int i = 0; i < 3; i++) begin
            exp_issue("R7", 2 * i, 0, rom_exp(i), 1'b1);
            exp_issue("R4", 2 * i + 1, 1, 32'hD100 + i, 1'b0);
        end
        exp_gaps("R4", 6, 1);

        // R9: events on threads without permission
        do_reset();
        pw[2] = 32'hE200_0001;
        push_en = 4'b0100;
        evt_req = 4'b1110;
        step();
        idle(12);
        chk("R9", "issue count with masked event", lg_n, 1);
        exp_issue("R9", 0, 2, 32'hE200_0001, 1'b0);
        lg_n = 0;
        evt_req = 4'b0010;
        step();
        idle(12);
        chk("R9", "masked event on empty thread", lg_n, 0);

        rec = 1'b0;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule